// File: doc/BRIEF.md
# Delta-Threshold Sparse Vector Encoder

This block turns a stream of dense vectors into a sparse stream of changes. Vector elements arrive one per accepted cycle, always in element order. For each element the block subtracts the value it last passed on for that position, and it forwards the change only when the change is large enough. A forwarded change leaves as a pair: a full-width signed delta and an index. A downstream matrix-vector engine uses the index directly as the address of the weight column that the delta multiplies.

Two reference banks are held, so one instance can encode both the fresh input sample and the previous hidden-state vector. Each bank has its own per-element references. A reference is replaced only when its element fires. Small drifts are therefore not lost: they add up until they cross the threshold. After the last element of every vector, an end marker carries the number of pairs that vector produced. This count can be zero.

Top module: `delta_encoder`

## Requirements
- R1: For each element, the emitted delta equals the incoming value minus the stored reference of the same element in the same bank.
- R2: An element emits a pair only when the magnitude of its delta is strictly greater than the threshold (unsigned). A magnitude equal to the threshold emits nothing.
- R3: A pair carries the full 16-bit two's-complement delta on `out_delta`. `out_index` holds the bank in its top bit and the element number (0 to NUM_ELEM-1) in its lower bits, so index = bank*NUM_ELEM + element.
- R4: A reference is overwritten with the incoming value only when that element fires. Changes below the threshold accumulate against the old reference until they exceed it.
- R5: After reset, all references are zero, the threshold is THR_RESET (default 0), and no pair or end marker is asserted.
- R6: Deltas saturate: a difference above 32767 gives 32767, and one below -32768 gives -32768.
- R7: Results appear exactly one cycle after the element is accepted. Pairs within a vector leave in ascending element order. A cycle with no accepted element produces neither a pair nor an end marker.
- R8: The cycle after the last element (element NUM_ELEM-1) is accepted, `eov_valid` pulses with `eov_count` equal to the number of pairs of that vector. A vector with no firing element gives a count of zero.
- R9: `in_bank` (0 = input sample, 1 = hidden state) is taken at element 0 and used for the whole vector. The two banks' references never affect each other.
- R10: A threshold write is used by every element accepted from the cycle after the write onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 16 | New unsigned threshold |
| in_valid | input | 1 | An element is presented this cycle |
| in_bank | input | 1 | Reference bank, sampled at element 0 |
| in_data | input | 16 | Signed element value |
| out_valid | output | 1 | A delta/index pair is valid |
| out_delta | output | 16 | Signed, saturated delta |
| out_index | output | 4 | {bank, element}, the weight column address |
| eov_valid | output | 1 | End of vector marker |
| eov_count | output | 4 | Pairs emitted by the finished vector |

## Verification
Every result is registered once, so the pair for an element and the end marker for the last element are both due one clock edge after the element is accepted. The bench presents each element on a falling edge. It then samples the outputs one time unit after the following rising edge, before the next element can be accepted, and so ties each observation to exactly one input. Idle cycles are inserted in one scenario and checked for silence in that same cycle. Threshold writes complete a full cycle before the next vector starts.

// File: rtl/delta_encoder.sv
module delta_encoder #(
  parameter int DW        = 16,
  parameter int NUM_ELEM  = 8,
  parameter int THR_RESET = 0,
  localparam int IDX_W    = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1,
  localparam int CNT_W    = $clog2(NUM_ELEM + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 thr_we,
  input  logic [DW-1:0]        thr_wdata,
  input  logic                 in_valid,
  input  logic                 in_bank,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_delta,
  output logic [IDX_W:0]       out_index,
  output logic                 eov_valid,
  output logic [CNT_W-1:0]     eov_count
);

  localparam int REF_DEPTH = 2 ** (IDX_W + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ELEM - 1);
  localparam logic signed [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0]        thr_q;
  logic [IDX_W-1:0]     elem_q;
  logic                 bank_q;
  logic [CNT_W-1:0]     cnt_q;
  logic signed [DW-1:0] refs [REF_DEPTH];

  logic                 cur_bank;
  logic [IDX_W:0]       addr;
  logic signed [DW-1:0] ref_val;
  logic [DW:0]          diff;
  logic signed [DW-1:0] delta;
  logic [DW:0]          mag;
  logic                 fire;
  logic                 is_last;

  assign cur_bank = (elem_q == '0) ? in_bank : bank_q;
  assign addr     = {cur_bank, elem_q};
  assign ref_val  = refs[addr];
  assign diff     = {in_data[DW-1], in_data} - {ref_val[DW-1], ref_val};
  assign delta    = (diff[DW] ^ diff[DW-1]) ? (diff[DW] ? SMIN : SMAX) : diff[DW-1:0];
  assign mag      = delta[DW-1] ? (~{1'b1, delta}) + (DW+1)'(1) : {1'b0, delta};
  assign fire     = in_valid && (mag > {1'b0, thr_q});
  assign is_last  = (elem_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q     <= DW'(THR_RESET);
      elem_q    <= '0;
      bank_q    <= 1'b0;
      cnt_q     <= '0;
      out_valid <= 1'b0;
      out_delta <= '0;
      out_index <= '0;
      eov_valid <= 1'b0;
      eov_count <= '0;
      for (int i = 0; i < REF_DEPTH; i++) refs[i] <= '0;
    end else begin
      if (thr_we) thr_q <= thr_wdata;
      out_valid <= fire;
      eov_valid <= in_valid && is_last;
      if (fire) begin
        out_delta  <= delta;
        out_index  <= addr;
        refs[addr] <= in_data;
      end
      if (in_valid) begin
        if (elem_q == '0) bank_q <= in_bank;
        if (is_last) begin
          elem_q    <= '0;
          cnt_q     <= '0;
          eov_count <= cnt_q + CNT_W'(fire);
        end else begin
          elem_q <= elem_q + IDX_W'(1);
          cnt_q  <= cnt_q + CNT_W'(fire);
        end
      end
    end
  end

  logic [DW:0]      out_mag;
  logic [IDX_W-1:0] chk_last_idx;
  logic             chk_any;
  logic [CNT_W-1:0] chk_pairs;

  assign out_mag = out_delta[DW-1] ? (~{1'b1, out_delta}) + (DW+1)'(1) : {1'b0, out_delta};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_last_idx <= '0;
      chk_any      <= 1'b0;
      chk_pairs    <= '0;
    end else if (eov_valid) begin
      chk_any   <= 1'b0;
      chk_pairs <= '0;
    end else if (out_valid) begin
      chk_last_idx <= out_index[IDX_W-1:0];
      chk_any      <= 1'b1;
      chk_pairs    <= chk_pairs + CNT_W'(1);
    end
  end

  assert_fire_above_thr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_mag > {1'b0, $past(thr_q)});

  assert_idle_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> (!out_valid && !eov_valid));

  assert_ascending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && chk_any) |-> out_index[IDX_W-1:0] > chk_last_idx);

  assert_eov_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eov_valid |-> eov_count == chk_pairs + CNT_W'(out_valid));

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eov_valid |-> eov_count <= CNT_W'(NUM_ELEM));

endmodule

// File: tb/tb_delta_encoder.sv
module tb_delta_encoder;
  localparam int NE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic thr_we = 1'b0;
  logic [15:0] thr_wdata = '0;
  logic in_valid = 1'b0;
  logic in_bank = 1'b0;
  logic signed [15:0] in_data = '0;
  logic out_valid;
  logic signed [15:0] out_delta;
  logic [3:0] out_index;
  logic eov_valid;
  logic [3:0] eov_count;

  int tests = 0;
  int fails = 0;
  int thr_m = 0;
  int refm [2][NE];
  int vec [NE];

  always #2.5 clk = ~clk;

  delta_encoder #(.DW(16), .NUM_ELEM(NE), .THR_RESET(0)) dut (
    .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .in_valid(in_valid), .in_bank(in_bank), .in_data(in_data),
    .out_valid(out_valid), .out_delta(out_delta), .out_index(out_index),
    .eov_valid(eov_valid), .eov_count(eov_count));

  task automatic check(input bit ok, input string msg);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic set_thr(input int v);
    @(negedge clk);
    thr_we = 1'b1;
    thr_wdata = 16'(v);
    @(negedge clk);
    thr_we = 1'b0;
    thr_m = v;
  endtask

  task automatic load_refs(input bit bank);
    for (int i = 0; i < NE; i++) vec[i] = refm[bank][i];
  endtask

  task automatic run_vector(input bit bank, input bit gap, input string tag);
    int cnt = 0;
    for (int i = 0; i < NE; i++) begin
      int d;
      int m;
      bit f;
      d = vec[i] - refm[bank][i];
      if (d > 32767) d = 32767;
      if (d < -32768) d = -32768;
      m = (d < 0) ? -d : d;
      f = (m > thr_m);
      @(negedge clk);
      in_valid = 1'b1;
      in_bank = bank;
      in_data = 16'(vec[i]);
      @(posedge clk);
      #1;
      if (f) begin
        refm[bank][i] = vec[i];
        cnt++;
      end
      check(out_valid == f && (!f || ($signed(out_delta) == d && int'(out_index) == bank * NE + i)),
            $sformatf("%s elem %0d: valid=%0b delta=%0d idx=%0d expected valid=%0b delta=%0d idx=%0d",
                      tag, i, out_valid, out_delta, out_index, f, d, bank * NE + i));
      if (i == NE - 1)
        check(eov_valid && int'(eov_count) == cnt,
              $sformatf("R8 %s end marker: eov=%0b count=%0d expected eov=1 count=%0d",
                        tag, eov_valid, eov_count, cnt));
      else
        check(!eov_valid, $sformatf("R8 %s early marker at elem %0d: eov=%0b expected 0", tag, i, eov_valid));
      if (gap) begin
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check(!out_valid && !eov_valid,
              $sformatf("R7 %s idle after elem %0d: valid=%0b eov=%0b expected 0 0", tag, i, out_valid, eov_valid));
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic test_reset();
    @(posedge clk);
    #1;
    check(!out_valid && !eov_valid,
          $sformatf("R5 reset outputs: valid=%0b eov=%0b expected 0 0", out_valid, eov_valid));
  endtask

  task automatic test_first_vector();
    vec = '{5, 0, -3, 0, 100, 0, 0, -32768};
    run_vector(1'b0, 1'b0, "R5/R1/R3 first vector");
  endtask

  task automatic test_strict_threshold();
    set_thr(10);
    vec = '{15, 11, -13, -11, 100, 0, 0, -32768};
    run_vector(1'b0, 1'b0, "R2 strict threshold");
  endtask

  task automatic test_accumulate();
    load_refs(1'b0);
    vec[0] = refm[0][0] + 5;
    run_vector(1'b0, 1'b0, "R4 accumulate step 1");
    load_refs(1'b0);
    vec[0] = refm[0][0] + 9;
    run_vector(1'b0, 1'b0, "R4 accumulate step 2");
    load_refs(1'b0);
    vec[0] = refm[0][0] + 11;
    run_vector(1'b0, 1'b0, "R4 accumulate crossing");
  endtask

  task automatic test_zero_vector();
    load_refs(1'b0);
    run_vector(1'b0, 1'b0, "R8 zero-count vector");
  endtask

  task automatic test_saturation();
    set_thr(0);
    load_refs(1'b0);
    vec[0] = 32767;
    run_vector(1'b0, 1'b0, "R6 saturation setup");
    vec[0] = -32768;
    run_vector(1'b0, 1'b0, "R6 negative saturation");
    vec[0] = 32767;
    run_vector(1'b0, 1'b0, "R6 positive saturation");
  endtask

  task automatic test_banks();
    vec = '{7, -7, 0, 300, 0, 1, -2, 0};
    run_vector(1'b1, 1'b0, "R9 hidden bank");
    load_refs(1'b0);
    run_vector(1'b0, 1'b0, "R9 input bank untouched");
  endtask

  task automatic test_gap();
    vec = '{-40, 3, 3, 3, 500, -500, 12, 9};
    run_vector(1'b1, 1'b1, "R7 gapped stream");
  endtask

  task automatic test_thr_write();
    set_thr(1000);
    load_refs(1'b1);
    vec[2] = refm[1][2] + 500;
    vec[5] = refm[1][5] - 1000;
    vec[6] = refm[1][6] + 1001;
    run_vector(1'b1, 1'b0, "R10 raised threshold");
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < NE; i++) refm[b][i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_first_vector();
    test_strict_threshold();
    test_accumulate();
    test_zero_vector();
    test_saturation();
    test_banks();
    test_gap();
    test_thr_write();
    repeat (2) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired: finished=0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule